// File: doc/BRIEF.md
# Cascaded Sliding-Sum Loss Threshold Filter

This block filters one stream of digitised, integrated loss samples and raises a beam-abort request when the filtered level is too high. Each accepted sample updates a running sum over the most recent `WIN` samples. The update is recursive: the new sample is added and the sample that leaves the window is subtracted, read from a circular RAM delay line of depth `WIN`. The cost per sample is one read and two add/subtract steps, for any window length. A second, identical stage takes the first sum as its input and sums it over `WIN` steps. Its output is a second-order comb-integrator result with a sinc² response, which rejects ripple better than a single sum.

Each of the two sums is compared, unsigned, against its own threshold input, and the result is shown on an over-threshold flag. A two-bit enable mask chooses which flags may trip the abort output. The abort output is latched and stays high until software acknowledges it. A small controller tracks how full the delay lines are and holds both published sums at zero until the window behind them is complete. It has three states. `ST_PRIME1` lasts while the first delay line fills. `ST_PRIME2` lasts while the second stage fills. `ST_RUN` is the steady state. There are two transitions: `ST_PRIME1 -> ST_PRIME2` on the `WIN`-th accepted sample, and `ST_PRIME2 -> ST_RUN` on the (2·`WIN`−1)-th accepted sample. `ST_RUN` is left only by reset.

Top module: `loss_sum_filter`

## Requirements
- R1: After reset both sums, both over-threshold flags and the abort output are 0.
- R2: `sum_fast` stays 0 until `WIN` samples have been accepted. From the clock edge that accepts sample n (0-based, n ≥ `WIN`−1), it equals the sum of samples n−`WIN`+1 through n.
- R3: A sample is accepted only on a rising clock edge with `smp_valid` high. When `smp_valid` is low, neither sum changes, whatever `smp_data` carries.
- R4: `sum_cic` stays 0 until 2·`WIN`−1 samples have been accepted. From then on it equals the sum of the last `WIN` values that `sum_fast` took, counting only values taken after its window was complete.
- R5: `over_fast` is 1 exactly when `sum_fast` > `thr_fast` (unsigned, strictly greater), and it follows the threshold input with no clock delay.
- R6: `over_cic` is 1 exactly when `sum_cic` > `thr_cic` (unsigned, strictly greater), and it follows the threshold input with no clock delay.
- R7: `trip_en` bit 0 lets `over_fast` trip the abort and bit 1 lets `over_cic` trip it. An enabled flag that is high sets `abort_o` on the next edge. A flag whose enable bit is 0 has no effect. `abort_o` never rises without an enabled flag in the cycle before.
- R8: `abort_o` stays 1 until an edge that sees `abort_ack` high with no enabled flag active, and it is 0 after that edge. If an enabled flag is still active, the acknowledge is ignored and `abort_o` stays 1.
- R9: With every sample at full scale (2^`DW`−1), the sums reach exactly `WIN`·(2^`DW`−1) and `WIN`²·(2^`DW`−1) without overflow, and they never exceed these bounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe: the sample is taken on this edge |
| smp_data | input | DW | Unsigned loss sample |
| thr_fast | input | S1W | Threshold for the single sliding sum |
| thr_cic | input | S2W | Threshold for the cascaded sum |
| trip_en | input | 2 | Abort enable mask: bit 0 for the fast sum, bit 1 for the cascaded sum |
| abort_ack | input | 1 | Clears the latched abort |
| sum_fast | output | S1W | Sliding sum of the last WIN samples |
| sum_cic | output | S2W | Sliding sum of the last WIN values of sum_fast |
| over_fast | output | 1 | sum_fast above thr_fast |
| over_cic | output | 1 | sum_cic above thr_cic |
| abort_o | output | 1 | Latched abort request |

## Verification
On every cycle, the assertions check the abort latch: when it is set, when it holds and when it clears, and that it never rises without a cause. They also check that idle cycles leave both sums frozen and that neither sum goes above its full-scale bound. The arithmetic itself is covered only by the bench's scenarios, which compare results against a model that keeps the sample history. These scenarios cover the exact value of each sum as the two delay lines fill, the zero hold during priming, the cascaded sum as the window slides, the strict boundary of each comparison, and the sums with a constant full-scale input.

// File: rtl/lsf_pkg.sv
package lsf_pkg;
    typedef enum logic [1:0] {
        ST_PRIME1 = 2'd0,
        ST_PRIME2 = 2'd1,
        ST_RUN    = 2'd2
    } lsf_state_e;
endpackage

// File: rtl/lsf_ctrl.sv
module lsf_ctrl
    import lsf_pkg::*;
#(
    parameter int WIN = 124,
    localparam int PW = $clog2(WIN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [PW-1:0] idx,
    output logic          fast_ready,
    output logic          cic_ready,
    output logic          step2,
    output logic          mask1,
    output logic          mask2
);
    localparam logic [PW-1:0] LAST = PW'(WIN - 1);
    localparam logic [PW-1:0] PRE_LAST = PW'(WIN - 2);

    lsf_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PRIME1;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME1: if (step && idx == LAST)     state_d = ST_PRIME2;
            ST_PRIME2: if (step && idx == PRE_LAST) state_d = ST_RUN;
            ST_RUN:    state_d = ST_RUN;
            default:   state_d = ST_PRIME1;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        fast_ready = 1'b0;
        cic_ready  = 1'b0;
        mask1      = 1'b1;
        mask2      = 1'b1;
        step2      = 1'b0;
        unique case (state_q)
            ST_PRIME1: step2 = step && (idx == LAST);
            ST_PRIME2: begin
                fast_ready = 1'b1;
                mask1      = 1'b0;
                step2      = step;
            end
            ST_RUN: begin
                fast_ready = 1'b1;
                cic_ready  = 1'b1;
                mask1      = 1'b0;
                mask2      = 1'b0;
                step2      = step;
            end
            default: ;
        endcase
    end

    // shared circular pointer
    always_ff @(posedge clk) begin
        if (!rst_n)    idx <= '0;
        else if (step) idx <= (idx == LAST) ? '0 : idx + 1'b1;
    end
endmodule

// File: rtl/lsf_stage.sv
module lsf_stage #(
    parameter int W     = 19,
    parameter int DEPTH = 124,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          mask_old,
    input  logic [AW-1:0] idx,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  acc_q,
    output logic [W-1:0]  acc_d
);
    logic [W-1:0] line [DEPTH];
    logic [W-1:0] old;

    // read of the leaving value precedes the write at the same slot
    assign old   = mask_old ? '0 : line[idx];
    assign acc_d = acc_q + din - old;

    always_ff @(posedge clk) begin
        if (!rst_n)    acc_q <= '0;
        else if (step) acc_q <= acc_d;
    end

    always_ff @(posedge clk) begin
        if (step) line[idx] <= din;
    end
endmodule

// File: rtl/loss_sum_filter.sv
module loss_sum_filter
    import lsf_pkg::*;
#(
    parameter int WIN = 124,
    parameter int DW  = 12,
    localparam int IW  = $clog2(WIN + 1),
    localparam int S1W = DW + IW,
    localparam int S2W = DW + 2 * IW,
    localparam int PW  = $clog2(WIN)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           smp_valid,
    input  logic [DW-1:0]  smp_data,
    input  logic [S1W-1:0] thr_fast,
    input  logic [S2W-1:0] thr_cic,
    input  logic [1:0]     trip_en,
    input  logic           abort_ack,
    output logic [S1W-1:0] sum_fast,
    output logic [S2W-1:0] sum_cic,
    output logic           over_fast,
    output logic           over_cic,
    output logic           abort_o
);
    logic [PW-1:0]  idx;
    logic           fast_ready, cic_ready, step2, mask1, mask2;
    logic [S1W-1:0] acc1_q, acc1_d;
    logic [S2W-1:0] acc2_q, acc2_d;
    logic           trip, abort_q;

    lsf_ctrl #(.WIN(WIN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .step(smp_valid), .idx(idx),
        .fast_ready(fast_ready), .cic_ready(cic_ready),
        .step2(step2), .mask1(mask1), .mask2(mask2)
    );

    lsf_stage #(.W(S1W), .DEPTH(WIN)) u_fast (
        .clk(clk), .rst_n(rst_n), .step(smp_valid), .mask_old(mask1),
        .idx(idx), .din(S1W'(smp_data)), .acc_q(acc1_q), .acc_d(acc1_d)
    );

    lsf_stage #(.W(S2W), .DEPTH(WIN)) u_cic (
        .clk(clk), .rst_n(rst_n), .step(step2), .mask_old(mask2),
        .idx(idx), .din(S2W'(acc1_d)), .acc_q(acc2_q), .acc_d(acc2_d)
    );

    assign sum_fast  = fast_ready ? acc1_q : '0;
    assign sum_cic   = cic_ready  ? acc2_q : '0;
    assign over_fast = sum_fast > thr_fast;
    assign over_cic  = sum_cic  > thr_cic;
    assign trip      = |(trip_en & {over_cic, over_fast});

    always_ff @(posedge clk) begin
        if (!rst_n) abort_q <= 1'b0;
        else        abort_q <= trip | (abort_q & ~abort_ack);
    end
    assign abort_o = abort_q;
endmodule

// File: rtl/lsf_chk.sv
module lsf_chk #(
    parameter int WIN = 124,
    parameter int DW  = 12,
    parameter int S1W = 19,
    parameter int S2W = 26
) (
    input logic           clk,
    input logic           rst_n,
    input logic           smp_valid,
    input logic [1:0]     trip_en,
    input logic           abort_ack,
    input logic [S1W-1:0] sum_fast,
    input logic [S2W-1:0] sum_cic,
    input logic           over_fast,
    input logic           over_cic,
    input logic           abort_o
);
    localparam longint FULL = (longint'(1) << DW) - 1;
    localparam logic [S1W-1:0] FAST_MAX = S1W'(longint'(WIN) * FULL);
    localparam logic [S2W-1:0] CIC_MAX  = S2W'(longint'(WIN) * WIN * FULL);

    logic cause;
    assign cause = |(trip_en & {over_cic, over_fast});

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> ($stable(sum_fast) && $stable(sum_cic)));

    p_fast_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sum_fast <= FAST_MAX);

    p_cic_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sum_cic <= CIC_MAX);

    p_trip_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cause |=> abort_o);

    p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abort_o) |-> $past(cause));

    p_abort_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_o && !abort_ack) |=> abort_o);

    p_abort_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_o && abort_ack && !cause) |=> !abort_o);
endmodule

bind loss_sum_filter lsf_chk #(.WIN(WIN), .DW(DW), .S1W(S1W), .S2W(S2W)) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .trip_en(trip_en),
    .abort_ack(abort_ack), .sum_fast(sum_fast), .sum_cic(sum_cic),
    .over_fast(over_fast), .over_cic(over_cic), .abort_o(abort_o)
);

// File: tb/loss_sum_filter_test.sv
`timescale 1ns/1ps
module loss_sum_filter_test;
    localparam int WIN = 8;
    localparam int DW  = 12;
    localparam int IW  = $clog2(WIN + 1);
    localparam int S1W = DW + IW;
    localparam int S2W = DW + 2 * IW;
    localparam int FULL = (1 << DW) - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           smp_valid = 1'b0;
    logic [DW-1:0]  smp_data = '0;
    logic [S1W-1:0] thr_fast = '1;
    logic [S2W-1:0] thr_cic = '1;
    logic [1:0]     trip_en = 2'b00;
    logic           abort_ack = 1'b0;
    logic [S1W-1:0] sum_fast;
    logic [S2W-1:0] sum_cic;
    logic           over_fast, over_cic, abort_o;

    int n_run = 0;
    int n_bad = 0;
    bit done = 0;
    longint xh [0:511];
    longint s1h [0:511];
    int nsmp = 0;
    longint exp_fast = 0, exp_cic = 0;
    int unsigned seed = 32'h1234_5678;

    always #2 clk = ~clk;

    loss_sum_filter #(.WIN(WIN), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .thr_fast(thr_fast), .thr_cic(thr_cic), .trip_en(trip_en),
        .abort_ack(abort_ack), .sum_fast(sum_fast), .sum_cic(sum_cic),
        .over_fast(over_fast), .over_cic(over_cic), .abort_o(abort_o)
    );

    task automatic check(input string req, input longint act, input longint expv);
        n_run++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; smp_valid = 1'b0; trip_en = 2'b00; abort_ack = 1'b0;
        thr_fast = '1; thr_cic = '1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        nsmp = 0; exp_fast = 0; exp_cic = 0;
    endtask

    // push one sample (called at a negedge), update model, compare sums
    task automatic push(input int x);
        longint s;
        smp_valid = 1'b1; smp_data = DW'(x);
        @(negedge clk);
        smp_valid = 1'b0;
        xh[nsmp] = x;
        s = 0;
        if (nsmp >= WIN - 1) begin
            for (int i = nsmp - WIN + 1; i <= nsmp; i++) s += xh[i];
            s1h[nsmp] = s;
        end
        exp_fast = s;
        exp_cic = 0;
        if (nsmp >= 2 * WIN - 2)
            for (int i = nsmp - WIN + 1; i <= nsmp; i++) exp_cic += s1h[i];
        nsmp++;
        check("R2 sum_fast", sum_fast, exp_fast);
        check("R4 sum_cic", sum_cic, exp_cic);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 sum_fast", sum_fast, 0);
        check("R1 sum_cic", sum_cic, 0);
        check("R1 over_fast", over_fast, 0);
        check("R1 over_cic", over_cic, 0);
        check("R1 abort_o", abort_o, 0);
    endtask

    task automatic t_fill_ramp();
        do_reset();
        for (int i = 0; i < 3 * WIN; i++) push(10 * i + 1);
    endtask

    task automatic t_idle();
        longint f, c;
        f = sum_fast; c = sum_cic;
        for (int i = 0; i < 5; i++) begin
            smp_data = DW'(777 + i);
            @(negedge clk);
            check("R3 idle sum_fast", sum_fast, f);
            check("R3 idle sum_cic", sum_cic, c);
        end
        push(5);
    endtask

    task automatic t_random();
        for (int i = 0; i < 40; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            push(int'((seed >> 16) % (FULL + 1)));
        end
    endtask

    task automatic t_compare();
        do_reset();
        for (int i = 0; i < 2 * WIN; i++) push(100);
        thr_fast = S1W'(exp_fast); #1;
        check("R5 equal not over", over_fast, 0);
        thr_fast = S1W'(exp_fast - 1); #1;
        check("R5 one below over", over_fast, 1);
        thr_cic = S2W'(exp_cic); #1;
        check("R6 equal not over", over_cic, 0);
        thr_cic = S2W'(exp_cic - 1); #1;
        check("R6 one below over", over_cic, 1);
        @(negedge clk);
        check("R7 disabled flags ignored", abort_o, 0);
        thr_fast = '1; thr_cic = '1;
    endtask

    task automatic t_abort();
        thr_fast = '0; trip_en = 2'b01;
        @(negedge clk);
        check("R7 fast trip", abort_o, 1);
        thr_fast = '1;
        repeat (3) @(negedge clk);
        check("R8 hold without ack", abort_o, 1);
        thr_fast = '0; abort_ack = 1'b1;
        @(negedge clk);
        check("R8 ack ignored while tripping", abort_o, 1);
        thr_fast = '1;
        @(negedge clk);
        abort_ack = 1'b0;
        check("R8 ack clears", abort_o, 0);
        trip_en = 2'b10; thr_fast = '0;
        @(negedge clk);
        check("R7 fast masked", abort_o, 0);
        thr_cic = '0;
        @(negedge clk);
        check("R7 cic trip", abort_o, 1);
        thr_cic = '1; thr_fast = '1; abort_ack = 1'b1;
        @(negedge clk);
        abort_ack = 1'b0; trip_en = 2'b00;
        check("R8 ack clears cic", abort_o, 0);
    endtask

    task automatic t_full();
        do_reset();
        for (int i = 0; i < 3 * WIN; i++) push(FULL);
        check("R9 fast full scale", sum_fast, longint'(WIN) * FULL);
        check("R9 cic full scale", sum_cic, longint'(WIN) * WIN * FULL);
    endtask

    initial begin
        t_reset();
        t_fill_ramp();
        t_idle();
        t_random();
        t_compare();
        t_abort();
        t_full();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end
endmodule